// File: doc/BRIEF.md
# Synchronous Flow-Through SRAM Model

This block is a synthesizable model of a single-data-rate synchronous static RAM with a flow-through read path and no dead cycle when the bus turns between reads and writes. An active-low clock enable qualifies every rising edge. Controls and address are captured only on a qualified edge. A cycle whose clock enable is high leaves the whole device exactly as it was. It does not count as a deselect.

An access begins when the load/advance control is low and the three chip selects agree. A write takes its data one qualified edge after its command, so a read or write command can follow a write command directly. A read presents its data in the cycle right after the edge that captured its address. The load/advance control can instead step a two-bit burst counter. The counter walks the low two address bits in linear or interleaved order. The bidirectional data bus is split into input, output and drive-enable signals. The drive enable combines an asynchronous active-low output enable with the captured access state.

Top module: `sfs_sram`

## Requirements
- R1: After reset the bus is not driven, no access is active, and every word reads as zero.
- R2: An edge with `cen_n` high changes nothing. The current access, the burst position, `dq_out` and any pending write data capture are all held, and `dq_in` is not written.
- R3: On a qualified edge with `adv_ld_n` low, the device is selected only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination deselects it, and `dq_oe` stays low while it is deselected.
- R4: A read loaded at a qualified edge puts the word at that address on `dq_out` in the cycle that follows that edge.
- R5: A write loaded at a qualified edge stores `dq_in` at the next qualified edge. Lane k is bits [9k+8:9k], and bit 9k+8 is that lane's parity bit. The lane is written only when `bw_n[k]` is 0 at the edge that presented the write's address.
- R6: A qualified edge with `adv_ld_n` high during an active access steps the burst. The upper address bits stay fixed. The low two bits become base+count mod 4 when `burst_ilv` was 0 at load, or base XOR count when it was 1, and the sequence wraps after four steps. For write bursts, each step samples `bw_n` again.
- R7: A qualified edge with `adv_ld_n` high while deselected leaves the device deselected, even when the chip selects are valid.
- R8: `dq_oe` is low through the data cycle of every write, even with `oe_n` low.
- R9: `dq_oe` is high only while a read is active and `oe_n` is low. It follows `oe_n` with no clock edge in between.
- R10: A read of an address whose write command came on the previous qualified edge returns the new data, with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write command when low at a load |
| adv_ld_n | input | 1 | Low: load new access; high: step burst |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| bw_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 9*LANES | Write data from the bus |
| dq_out | output | 9*LANES | Read data toward the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
On every cycle, the checker confirms several rules: a stalled edge holds `dq_out` and the access state, the bus is never driven without `oe_n` low, a write command or a deselect leaves the bus quiet in the next cycle, a selected read drives it when output enable allows, and advancing while idle keeps the device idle. The bench's scenarios cover the data itself. These include masked lane merges with parity, linear and interleaved burst orders with their wrap, write data held across a stall, and read-after-write with no gap.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        CMD_HOLD    = 3'd0,
        CMD_LOAD_RD = 3'd1,
        CMD_LOAD_WR = 3'd2,
        CMD_DESEL   = 3'd3,
        CMD_ADV     = 3'd4
    } cmd_e;

    // Low two address bits for burst position cnt from starting point base.
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/sfs_decode.sv
module sfs_decode
    import sfs_pkg::*;
(
    input  logic cen_n,
    input  logic ce1_n,
    input  logic ce2,
    input  logic ce3_n,
    input  logic we_n,
    input  logic adv_ld_n,
    output cmd_e cmd
);
    logic sel;
    assign sel = !ce1_n && ce2 && !ce3_n;

    always_comb begin
        if (cen_n)
            cmd = CMD_HOLD;
        else if (adv_ld_n)
            cmd = CMD_ADV;
        else if (sel)
            cmd = we_n ? CMD_LOAD_RD : CMD_LOAD_WR;
        else
            cmd = CMD_DESEL;
    end
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
    import sfs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_ilv,
    input  logic [LANES-1:0]  bw_n,
    output op_e               cur_op,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LANES-1:0]  cur_bw_n,
    output logic              wr_commit
);
    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic              ilv;
        logic [LANES-1:0]  bw_n;
    } acc_t;

    acc_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.op   <= OP_IDLE;
            st.base <= '0;
            st.cnt  <= '0;
            st.ilv  <= 1'b0;
            st.bw_n <= '1;
        end else begin
            case (cmd)
                CMD_LOAD_RD, CMD_LOAD_WR: begin
                    st.op   <= (cmd == CMD_LOAD_WR) ? OP_WR : OP_RD;
                    st.base <= addr;
                    st.cnt  <= '0;
                    st.ilv  <= burst_ilv;
                    st.bw_n <= bw_n;
                end
                CMD_DESEL: st.op <= OP_IDLE;
                CMD_ADV: begin
                    if (st.op != OP_IDLE) begin
                        st.cnt  <= st.cnt + 2'd1;
                        st.bw_n <= bw_n;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cur_op    = st.op;
    assign cur_bw_n  = st.bw_n;
    assign cur_addr  = {st.base[ADDR_W-1:2], burst_low(st.base[1:0], st.cnt, st.ilv)};
    // Write data belongs to the access captured at the previous qualified edge.
    assign wr_commit = (cmd != CMD_HOLD) && (st.op == OP_WR);
endmodule

// File: rtl/sfs_lane.sv
module sfs_lane
    import sfs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Flow-through: read is combinational from the captured address.
    assign rdata = mem[addr];
endmodule

// File: rtl/sfs_sram.sv
module sfs_sram
    import sfs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              we_n,
    input  logic              adv_ld_n,
    input  logic              burst_ilv,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    cmd_e              cmd;
    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  cur_bw_n;
    logic              wr_commit;

    sfs_decode u_dec (
        .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .we_n(we_n), .adv_ld_n(adv_ld_n), .cmd(cmd)
    );

    sfs_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .burst_ilv(burst_ilv),
        .bw_n(bw_n), .cur_op(cur_op), .cur_addr(cur_addr),
        .cur_bw_n(cur_bw_n), .wr_commit(wr_commit)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sfs_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk(clk), .rst(rst),
            .we(wr_commit && !cur_bw_n[k]),
            .addr(cur_addr),
            .wdata(dq_in[k*LANE_W +: LANE_W]),
            .rdata(dq_out[k*LANE_W +: LANE_W])
        );
    end

    assign dq_oe = !oe_n && (cur_op == OP_RD);
endmodule

// File: rtl/sfs_sram_chk.sv
module sfs_sram_chk
    import sfs_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              cen_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              we_n,
    input logic              adv_ld_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input op_e               cur_op
);
    logic sel_ok;
    assign sel_ok = !ce1_n && ce2 && !ce3_n;

    a_r9_oe_gate: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !oe_n);

    a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(dq_out) && $stable(cur_op)));

    a_r3_desel_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld_n && !sel_ok) |=> !dq_oe);

    a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld_n && sel_ok && !we_n) |=> !dq_oe);

    a_r4_read_drive: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld_n && sel_ok && we_n) |=> (oe_n || dq_oe));

    a_r7_adv_idle: assert property (@(posedge clk) disable iff (rst)
        (cur_op == OP_IDLE && adv_ld_n) |=> (cur_op == OP_IDLE));
endmodule

bind sfs_sram sfs_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .we_n(we_n), .adv_ld_n(adv_ld_n), .oe_n(oe_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .cur_op(cur_op)
);

// File: tb/sfs_sram_test.sv
module sfs_sram_test;
    localparam int LANES = 4;
    localparam int AW    = 6;
    localparam int DW    = LANES * 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cen_n = 1'b1, ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic we_n = 1'b1, adv_ld_n = 1'b0, burst_ilv = 1'b0, oe_n = 1'b0;
    logic [LANES-1:0] bw_n = '1;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    dq_in = '0;
    logic [DW-1:0]    dq_out;
    logic             dq_oe;

    int n_chk = 0, n_fail = 0;

    // Bench-side model: 0 idle, 1 read, 2 write.
    int              m_op = 0;
    logic [AW-1:0]   m_base = '0;
    logic [1:0]      m_cnt = '0;
    logic            m_ilv = 1'b0;
    logic [LANES-1:0] m_bw = '1;
    logic [DW-1:0]   ref_mem [int];

    sfs_sram #(.LANES(LANES), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .we_n(we_n), .adv_ld_n(adv_ld_n), .burst_ilv(burst_ilv),
        .bw_n(bw_n), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #2 clk = ~clk;

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] rd_ref(input logic [AW-1:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
    endfunction

    task automatic tick();
        @(posedge clk);
        if (!rst && !cen_n) begin
            if (m_op == 2) begin
                logic [DW-1:0] w;
                w = rd_ref(m_addr());
                for (int k = 0; k < LANES; k++)
                    if (!m_bw[k]) w[k*9 +: 9] = dq_in[k*9 +: 9];
                ref_mem[int'(m_addr())] = w;
            end
            if (adv_ld_n) begin
                if (m_op != 0) begin m_cnt = m_cnt + 2'd1; m_bw = bw_n; end
            end else if (!ce1_n && ce2 && !ce3_n) begin
                m_op = we_n ? 1 : 2; m_base = addr; m_cnt = '0;
                m_ilv = burst_ilv; m_bw = bw_n;
            end else begin
                m_op = 0;
            end
        end
        #1;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bus(input string req);
        chk(req, DW'(dq_oe), DW'((m_op == 1) && !oe_n));
        if (m_op == 1) chk(req, dq_out, rd_ref(m_addr()));
    endtask

    task automatic set_load(input logic [AW-1:0] a, input logic wr,
                            input logic [LANES-1:0] bw, input logic ilv);
        cen_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        adv_ld_n = 1'b0; we_n = !wr; addr = a; bw_n = bw; burst_ilv = ilv;
    endtask

    task automatic set_adv(input logic [LANES-1:0] bw);
        cen_n = 1'b0; adv_ld_n = 1'b1; bw_n = bw;
    endtask

    localparam logic [DW-1:0] D1 = 36'h1_2345_6789;
    localparam logic [DW-1:0] DX = 36'hA_AAAA_AAAA;
    localparam logic [DW-1:0] DY = 36'h5_5555_5555;

    task automatic t_reset();
        chk("R1 no drive after reset", DW'(dq_oe), '0);
        set_load(6'd5, 1'b0, '1, 1'b0); tick();
        chk("R1 cleared word", dq_out, '0);
        chk_bus("R1 R4 read after reset");
    endtask

    task automatic t_write_read();
        set_load(6'd3, 1'b1, '0, 1'b0); tick();
        chk("R8 write data cycle undriven", DW'(dq_oe), '0);
        set_load(6'd3, 1'b0, '1, 1'b0); dq_in = D1; tick();
        chk("R10 read right after write", dq_out, D1);
        chk_bus("R4 R5 bus after write");
    endtask

    task automatic t_byte_mask();
        set_load(6'd7, 1'b1, '0, 1'b0); tick();
        set_load(6'd7, 1'b1, 4'b0101, 1'b0); dq_in = DX; tick();
        set_load(6'd7, 1'b0, '1, 1'b0); dq_in = DY; tick();
        chk("R5 lane merge with parity", dq_out, {DY[35:27], DX[26:18], DY[17:9], DX[8:0]});
        chk_bus("R5 masked write model");
    endtask

    task automatic t_stall();
        logic [DW-1:0] held;
        held = dq_out;
        cen_n = 1'b1; adv_ld_n = 1'b0; we_n = 1'b0; addr = 6'd20; bw_n = '0; dq_in = '1;
        tick(); tick(); tick();
        chk("R2 output held in stall", dq_out, held);
        chk("R2 drive held in stall", DW'(dq_oe), 1);
        set_load(6'd9, 1'b1, '0, 1'b0); tick();
        cen_n = 1'b1; dq_in = DX; tick(); tick();
        set_load(6'd9, 1'b0, '1, 1'b0); dq_in = DY; tick();
        chk("R2 write data waits for enabled edge", dq_out, DY);
        chk_bus("R2 stall model");
    endtask

    task automatic t_deselect();
        for (int v = 0; v < 3; v++) begin
            set_load(6'd3, 1'b0, '1, 1'b0);
            if (v == 0) ce1_n = 1'b1;
            if (v == 1) ce2 = 1'b0;
            if (v == 2) ce3_n = 1'b1;
            tick();
            chk("R3 deselected bus quiet", DW'(dq_oe), '0);
            ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
            set_adv('1); tick();
            chk("R7 advance while deselected", DW'(dq_oe), '0);
        end
        set_load(6'd3, 1'b0, '1, 1'b0); tick();
        chk("R3 reselect read", dq_out, D1);
        chk("R3 reselect drive", DW'(dq_oe), 1);
    endtask

    task automatic t_burst();
        // Linear write burst from 10: 10, 11, 8, 9.
        set_load(6'd10, 1'b1, '0, 1'b0); tick();
        set_adv('0); dq_in = 36'h0_0000_0A00; tick();
        chk("R8 burst write undriven", DW'(dq_oe), '0);
        dq_in = 36'h0_0000_0B11; tick();
        dq_in = 36'h0_0000_0C22; tick();
        // Interleaved read from 9: 9, 8, 11, 10, then wraps to 9.
        set_load(6'd9, 1'b0, '1, 1'b1); dq_in = 36'h0_0000_0D33; tick();
        chk("R6 ilv step0 addr9", dq_out, 36'h0_0000_0D33);
        set_adv('1); tick();
        chk("R6 ilv step1 addr8", dq_out, 36'h0_0000_0C22);
        tick();
        chk("R6 ilv step2 addr11", dq_out, 36'h0_0000_0B11);
        tick();
        chk("R6 ilv step3 addr10", dq_out, 36'h0_0000_0A00);
        tick();
        chk("R6 ilv wrap addr9", dq_out, 36'h0_0000_0D33);
        // Linear read from 11: 11, 8.
        set_load(6'd11, 1'b0, '1, 1'b0); tick();
        chk("R6 lin step0 addr11", dq_out, 36'h0_0000_0B11);
        set_adv('1); tick();
        chk("R6 lin wrap addr8", dq_out, 36'h0_0000_0C22);
        chk_bus("R6 burst model");
    endtask

    task automatic t_oe();
        oe_n = 1'b1; #1;
        chk("R9 oe high releases bus", DW'(dq_oe), '0);
        oe_n = 1'b0; #1;
        chk("R9 oe low drives bus", DW'(dq_oe), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_write_read();
        t_byte_mask();
        t_stall();
        t_deselect();
        t_burst();
        t_oe();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule